// File: doc/BRIEF.md
# Pointer-register address generation unit

This unit produces addresses for indirect accesses in a small 8-bit controller core. It owns the upper eight working registers (numbers 24 to 31), which form four 16-bit pairs. Three of the pairs serve as memory pointers: X, Y and Z. The first pair, 24/25, can only take part in word add and subtract. For each request the unit computes the effective data-memory address. It then writes the updated pointer back at the same clock edge. The byte access itself is carried out by the memory next to it.

A program-memory byte read goes through Z. In that cycle the unit issues the word address. One cycle later it takes in the returned 16-bit word and delivers the selected byte for register 0. A small state machine with two states orders this sequence:
- READY accepts requests.
- The transition READY→PMWAIT is taken on a legal program-memory read.
- PMWAIT completes the byte return.
- The transition PMWAIT→READY is unconditional.

Illegal requests raise an error and change nothing.

Top module: `agu_top`

## Requirements
- R1: Register index i on the byte ports (i = 0..7) names working register 24+i. Selector 0 is pair 24/25, 1 is X (26/27), 2 is Y (28/29) and 3 is Z (30/31). In each pair the even register holds the low byte. `rd_data` shows register `rd_idx` combinationally, and `reg_we` writes `reg_wdata` at the clock edge.
- R2: Request code 0 (plain indirect) drives `mem_addr` with the pointer and leaves the pointer unchanged. `mem_we` follows `req_store` whenever `mem_valid` is high.
- R3: Request code 1 (post-increment) accesses the pointer value and stores pointer+1 at the same edge. The update wraps from 0xFFFF to 0x0000.
- R4: Request code 2 (pre-decrement) accesses pointer−1 and stores that value at the same edge. The update wraps from 0x0000 to 0xFFFF.
- R5: Request code 3 (displacement) is legal on Y and Z only. It accesses pointer plus the unsigned 6-bit `req_imm`, modulo 2^16, and leaves the pointer unchanged.
- R6: Request code 4 (program byte read) is legal on Z only. In the request cycle it raises `pm_rd` with `pm_waddr` equal to Z shifted right by one. In the next cycle `busy` and `r0_we` are high, and `r0_data` is `pm_rdata[7:0]` if Z bit 0 was 0 and `pm_rdata[15:8]` if it was 1. Z is not changed.
- R7: Request codes 5 and 6 add or subtract the zero-extended `req_imm` on any of the four pairs and write the result back. They raise `flag_we` with `flags` = {overflow, negative, zero, carry/borrow} (bit 3 down to bit 0).
- R8: Memory requests (codes 0–3) and program reads (code 4) never raise `flag_we`.
- R9: The following requests raise `err` and produce no `mem_valid`, no `pm_rd`, no `flag_we` and no register change:
  - codes 0–3 on selector 0;
  - code 3 on X;
  - code 4 on any pointer other than Z;
  - code 7;
  - any request while `busy`.
- R10: When a pointer update and a `reg_we` write hit the same register in one cycle, the pointer update wins. A `reg_we` write to another register still takes effect.
- R11: After reset all eight registers read 0, the state is READY, and `err`, `busy`, `mem_valid`, `pm_rd`, `r0_we` and `flag_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request code (0..7, see R2–R9) |
| req_sel | input | 2 | Pair selector |
| req_imm | input | 6 | Unsigned displacement or word constant |
| req_store | input | 1 | 1 for a store, 0 for a load |
| reg_we | input | 1 | Byte write to a pair register |
| reg_idx | input | 3 | Register index for the write (24+idx) |
| reg_wdata | input | 8 | Byte to write |
| rd_idx | input | 3 | Register index for readback |
| rd_data | output | 8 | Readback byte |
| mem_valid | output | 1 | Data-memory access this cycle |
| mem_we | output | 1 | Data-memory access is a store |
| mem_addr | output | 16 | Effective byte address |
| pm_rd | output | 1 | Program-memory word read issued |
| pm_waddr | output | 15 | Program-memory word address |
| pm_rdata | input | 16 | Program-memory word, one cycle after pm_rd |
| r0_we | output | 1 | Write the returned byte to register 0 |
| r0_data | output | 8 | Byte for register 0 |
| flag_we | output | 1 | Status flags update from a word add/subtract |
| flags | output | 4 | {V, N, Z, C} of the word result |
| err | output | 1 | Illegal request, suppressed |
| busy | output | 1 | Program read in its return cycle |

## Verification
The bench targets the two wrap points. A pointer at 0xFFFF is post-incremented, and one at 0x0000 is pre-decremented. A design with a short adder or a missing carry would write back a wrong high byte. Displacement past 0xFFFF and the byte select for program reads are also checked. Swapping the halves or using Z instead of Z>>1 would give the wrong byte or the wrong word address.

Illegal requests are checked by reading the pointer back afterwards. A design that suppressed only the access and still updated the pointer would be caught there. The same-register collision is also exercised: if the external write won, the incremented low byte would be lost. Word add and subtract flags are checked at the carry and borrow boundaries, where a wrong carry or overflow rule would show.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [2:0] {
        OP_PLAIN   = 3'd0,
        OP_POSTINC = 3'd1,
        OP_PREDEC  = 3'd2,
        OP_DISP    = 3'd3,
        OP_PMEM    = 3'd4,
        OP_WADD    = 3'd5,
        OP_WSUB    = 3'd6,
        OP_RSVD    = 3'd7
    } agu_op_e;

    typedef enum logic {
        ST_READY  = 1'b0,
        ST_PMWAIT = 1'b1
    } agu_state_e;

    localparam logic [1:0] SEL_W = 2'd0;
    localparam logic [1:0] SEL_X = 2'd1;
    localparam logic [1:0] SEL_Y = 2'd2;
    localparam logic [1:0] SEL_Z = 2'd3;

endpackage

// File: rtl/agu_ptr_file.sv
module agu_ptr_file #(
    parameter int DW    = 8,
    parameter int NPAIR = 4,
    localparam int PW   = 2 * DW,
    localparam int NREG = 2 * NPAIR,
    localparam int IW   = $clog2(NREG),
    localparam int SW   = $clog2(NPAIR)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ext_we,
    input  logic [IW-1:0]               ext_idx,
    input  logic [DW-1:0]               ext_wdata,
    input  logic                        upd_we,
    input  logic [SW-1:0]               upd_pair,
    input  logic [PW-1:0]               upd_val,
    input  logic [IW-1:0]               rd_idx,
    output logic [DW-1:0]               rd_data,
    output logic [NPAIR-1:0][PW-1:0]    pairs
);

    logic [NREG-1:0][DW-1:0] regs_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam int PAIR = g / 2;
        localparam int HI   = g % 2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (upd_we && upd_pair == SW'(PAIR)) begin
                regs_q[g] <= upd_val[HI*DW +: DW];
            end else if (ext_we && ext_idx == IW'(g)) begin
                regs_q[g] <= ext_wdata;
            end
        end
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pairs[p] = {regs_q[2*p+1], regs_q[2*p]};
    end

    assign rd_data = regs_q[rd_idx];

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
    import agu_pkg::*;
#(
    parameter int DW   = 8,
    parameter int OFFW = 6,
    localparam int PW  = 2 * DW
) (
    input  agu_op_e          op,
    input  logic [1:0]       sel,
    input  logic [OFFW-1:0]  imm,
    input  logic [PW-1:0]    ptr,
    input  logic             busy,
    output logic             legal,
    output logic             mem_acc,
    output logic             pm_acc,
    output logic             wb_en,
    output logic             flag_en,
    output logic [PW-1:0]    addr,
    output logic [PW-1:0]    wb_val,
    output logic [3:0]       flag_val
);

    logic [PW-1:0] imm_w;
    logic [PW:0]   sum_w;
    logic [PW:0]   dif_w;
    logic [PW-1:0] res;
    logic          cout;

    assign imm_w = {{(PW-OFFW){1'b0}}, imm};
    assign sum_w = {1'b0, ptr} + {1'b0, imm_w};
    assign dif_w = {1'b0, ptr} - {1'b0, imm_w};

    always_comb begin
        legal   = 1'b0;
        mem_acc = 1'b0;
        pm_acc  = 1'b0;
        wb_en   = 1'b0;
        flag_en = 1'b0;
        addr    = ptr;
        wb_val  = ptr;
        res     = sum_w[PW-1:0];
        cout    = sum_w[PW];
        case (op)
            OP_PLAIN: begin
                legal   = (sel != SEL_W);
                mem_acc = 1'b1;
            end
            OP_POSTINC: begin
                legal   = (sel != SEL_W);
                mem_acc = 1'b1;
                wb_en   = 1'b1;
                wb_val  = ptr + PW'(1);
            end
            OP_PREDEC: begin
                legal   = (sel != SEL_W);
                mem_acc = 1'b1;
                wb_en   = 1'b1;
                addr    = ptr - PW'(1);
                wb_val  = ptr - PW'(1);
            end
            OP_DISP: begin
                legal   = (sel == SEL_Y) || (sel == SEL_Z);
                mem_acc = 1'b1;
                addr    = sum_w[PW-1:0];
            end
            OP_PMEM: begin
                legal  = (sel == SEL_Z);
                pm_acc = 1'b1;
            end
            OP_WADD: begin
                legal   = 1'b1;
                wb_en   = 1'b1;
                flag_en = 1'b1;
                res     = sum_w[PW-1:0];
                cout    = sum_w[PW];
                wb_val  = res;
            end
            OP_WSUB: begin
                legal   = 1'b1;
                wb_en   = 1'b1;
                flag_en = 1'b1;
                res     = dif_w[PW-1:0];
                cout    = dif_w[PW];
                wb_val  = res;
            end
            default: legal = 1'b0;
        endcase
        legal = legal && !busy;
    end

    always_comb begin
        flag_val[0] = cout;
        flag_val[1] = (res == '0);
        flag_val[2] = res[PW-1];
        if (op == OP_WSUB) begin
            flag_val[3] = ptr[PW-1] & ~res[PW-1];
        end else begin
            flag_val[3] = ~ptr[PW-1] & res[PW-1];
        end
    end

endmodule

// File: rtl/agu_pm_seq.sv
module agu_pm_seq
    import agu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pm_start,
    input  logic byte_sel,
    output logic busy,
    output logic r0_we,
    output logic hi_sel
);

    agu_state_e state_q;
    agu_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            hi_sel  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (pm_start) begin
                hi_sel <= byte_sel;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        busy    = 1'b0;
        r0_we   = 1'b0;
        unique case (state_q)
            ST_READY: begin
                if (pm_start) begin
                    state_d = ST_PMWAIT;
                end
            end
            ST_PMWAIT: begin
                busy    = 1'b1;
                r0_we   = 1'b1;
                state_d = ST_READY;
            end
        endcase
    end

endmodule

// File: rtl/agu_top.sv
module agu_top
    import agu_pkg::*;
#(
    parameter int DW    = 8,
    parameter int OFFW  = 6,
    parameter int NPAIR = 4,
    localparam int PW   = 2 * DW,
    localparam int IW   = $clog2(2 * NPAIR),
    localparam int SW   = $clog2(NPAIR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [SW-1:0]   req_sel,
    input  logic [OFFW-1:0] req_imm,
    input  logic            req_store,
    input  logic            reg_we,
    input  logic [IW-1:0]   reg_idx,
    input  logic [DW-1:0]   reg_wdata,
    input  logic [IW-1:0]   rd_idx,
    output logic [DW-1:0]   rd_data,
    output logic            mem_valid,
    output logic            mem_we,
    output logic [PW-1:0]   mem_addr,
    output logic            pm_rd,
    output logic [PW-2:0]   pm_waddr,
    input  logic [PW-1:0]   pm_rdata,
    output logic            r0_we,
    output logic [DW-1:0]   r0_data,
    output logic            flag_we,
    output logic [3:0]      flags,
    output logic            err,
    output logic            busy
);

    logic [NPAIR-1:0][PW-1:0] pair_q;
    logic [PW-1:0]            ptr_sel;
    logic                     legal, mem_acc, pm_acc, wb_en, flag_en;
    logic [PW-1:0]            wb_val;
    logic                     upd_we;
    logic                     hi_sel;

    assign ptr_sel = pair_q[req_sel];

    agu_addr_calc #(.DW(DW), .OFFW(OFFW)) u_calc (
        .op       (agu_op_e'(req_op)),
        .sel      (req_sel),
        .imm      (req_imm),
        .ptr      (ptr_sel),
        .busy     (busy),
        .legal    (legal),
        .mem_acc  (mem_acc),
        .pm_acc   (pm_acc),
        .wb_en    (wb_en),
        .flag_en  (flag_en),
        .addr     (mem_addr),
        .wb_val   (wb_val),
        .flag_val (flags)
    );

    assign err       = req_valid && !legal;
    assign mem_valid = req_valid && legal && mem_acc;
    assign mem_we    = mem_valid && req_store;
    assign pm_rd     = req_valid && legal && pm_acc;
    assign flag_we   = req_valid && legal && flag_en;
    assign upd_we    = req_valid && legal && wb_en;
    assign pm_waddr  = ptr_sel[PW-1:1];

    agu_ptr_file #(.DW(DW), .NPAIR(NPAIR)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_we    (reg_we),
        .ext_idx   (reg_idx),
        .ext_wdata (reg_wdata),
        .upd_we    (upd_we),
        .upd_pair  (req_sel),
        .upd_val   (wb_val),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .pairs     (pair_q)
    );

    agu_pm_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pm_start (pm_rd),
        .byte_sel (ptr_sel[0]),
        .busy     (busy),
        .r0_we    (r0_we),
        .hi_sel   (hi_sel)
    );

    assign r0_data = hi_sel ? pm_rdata[PW-1:DW] : pm_rdata[DW-1:0];

endmodule

// File: rtl/agu_checks.sv
module agu_checks
    import agu_pkg::*;
#(
    parameter int DW    = 8,
    parameter int NPAIR = 4,
    localparam int PW   = 2 * DW,
    localparam int SW   = $clog2(NPAIR)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [2:0]               req_op,
    input logic [SW-1:0]            req_sel,
    input logic                     reg_we,
    input logic                     mem_valid,
    input logic [PW-1:0]            mem_addr,
    input logic                     pm_rd,
    input logic                     r0_we,
    input logic                     flag_we,
    input logic                     err,
    input logic                     busy,
    input logic [NPAIR-1:0][PW-1:0] pairs
);

    // R9: a rejected request produces no side effect this cycle
    a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!mem_valid && !pm_rd && !flag_we));

    // R9: requests during the return cycle are rejected
    a_r9_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |-> err);

    // R8: memory and program reads leave the flags alone
    a_r8_no_flag_on_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid || pm_rd) |-> !flag_we);

    // R3: post-increment writes back address plus one
    a_r3_postinc_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && req_op == OP_POSTINC)
        |=> (pairs[$past(req_sel)] == PW'($past(mem_addr) + PW'(1))));

    // R4: pre-decrement accesses pointer minus one
    a_r4_predec_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && req_op == OP_PREDEC)
        |-> (mem_addr == PW'(pairs[req_sel] - PW'(1))));

    // R4: pre-decrement leaves the pointer at the accessed address
    a_r4_predec_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && req_op == OP_PREDEC)
        |=> (pairs[$past(req_sel)] == $past(mem_addr)));

    // R5: displacement access keeps the pointer
    a_r5_disp_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && req_op == OP_DISP && !reg_we)
        |=> (pairs[$past(req_sel)] == $past(pairs[req_sel])));

    // R6: every program read is followed by a byte return
    a_r6_pm_return: assert property (@(posedge clk) disable iff (!rst_n)
        pm_rd |=> r0_we);

    // R6: a byte return only follows a program read
    a_r6_r0_cause: assert property (@(posedge clk) disable iff (!rst_n)
        r0_we |-> $past(pm_rd));

endmodule

bind agu_top agu_checks #(.DW(DW), .NPAIR(NPAIR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_sel   (req_sel),
    .reg_we    (reg_we),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .pm_rd     (pm_rd),
    .r0_we     (r0_we),
    .flag_we   (flag_we),
    .err       (err),
    .busy      (busy),
    .pairs     (pair_q)
);

// File: tb/sim_agu_top.sv
module sim_agu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_sel = '0;
    logic [5:0]  req_imm = '0;
    logic        req_store = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic [2:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic        mem_valid, mem_we;
    logic [15:0] mem_addr;
    logic        pm_rd;
    logic [14:0] pm_waddr;
    logic [15:0] pm_rdata = '0;
    logic        r0_we;
    logic [7:0]  r0_data;
    logic        flag_we;
    logic [3:0]  flags;
    logic        err, busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    agu_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_imm(req_imm), .req_store(req_store),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .rd_idx(rd_idx), .rd_data(rd_data), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .pm_rd(pm_rd),
        .pm_waddr(pm_waddr), .pm_rdata(pm_rdata), .r0_we(r0_we),
        .r0_data(r0_data), .flag_we(flag_we), .flags(flags), .err(err),
        .busy(busy)
    );

    // {op, sel, imm, init, exp_addr, exp_ptr, exp_err}
    localparam int NV = 14;
    localparam logic [59:0] VEC [NV] = '{
        {3'd0, 2'd1, 6'd0,  16'h1234, 16'h1234, 16'h1234, 1'b0}, // R2 plain X
        {3'd1, 2'd2, 6'd0,  16'h00FF, 16'h00FF, 16'h0100, 1'b0}, // R3 carry into high byte
        {3'd1, 2'd3, 6'd0,  16'hFFFF, 16'hFFFF, 16'h0000, 1'b0}, // R3 wrap
        {3'd2, 2'd1, 6'd0,  16'h0100, 16'h00FF, 16'h00FF, 1'b0}, // R4 borrow
        {3'd2, 2'd2, 6'd0,  16'h0000, 16'hFFFF, 16'hFFFF, 1'b0}, // R4 wrap
        {3'd3, 2'd2, 6'd63, 16'h1000, 16'h103F, 16'h1000, 1'b0}, // R5 max offset
        {3'd3, 2'd3, 6'd32, 16'hFFF0, 16'h0010, 16'hFFF0, 1'b0}, // R5 wrap
        {3'd3, 2'd1, 6'd5,  16'h2222, 16'h0000, 16'h2222, 1'b1}, // R9 disp on X
        {3'd0, 2'd0, 6'd0,  16'h3333, 16'h0000, 16'h3333, 1'b1}, // R9 memory on pair 24
        {3'd5, 2'd0, 6'd1,  16'h00FF, 16'h0000, 16'h0100, 1'b0}, // R7 add
        {3'd6, 2'd3, 6'd1,  16'h0000, 16'h0000, 16'hFFFF, 1'b0}, // R7 subtract borrow
        {3'd5, 2'd1, 6'd63, 16'hFFC1, 16'h0000, 16'h0000, 1'b0}, // R7 add carry out
        {3'd7, 2'd2, 6'd0,  16'h4444, 16'h0000, 16'h4444, 1'b1}, // R9 undefined code
        {3'd4, 2'd1, 6'd0,  16'h5555, 16'h0000, 16'h5555, 1'b1}  // R9 program read on X
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [7:0] val);
        reg_we = 1'b1;
        reg_idx = idx;
        reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic load_pair(input logic [1:0] sel, input logic [15:0] val);
        wr_reg({sel, 1'b0}, val[7:0]);
        wr_reg({sel, 1'b1}, val[15:8]);
    endtask

    task automatic read_pair(input logic [1:0] sel, output logic [15:0] val);
        rd_idx = {sel, 1'b0};
        #1 val[7:0] = rd_data;
        rd_idx = {sel, 1'b1};
        #1 val[15:8] = rd_data;
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] sel, input logic [5:0] imm);
        req_valid = 1'b1;
        req_op = op;
        req_sel = sel;
        req_imm = imm;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] p;
        logic [16:0] s;
        logic [3:0]  ef;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        for (int k = 0; k < 4; k++) begin
            read_pair(2'(k), p);
            check("R11 pair after reset", p, 0);
        end
        check("R11 outputs idle", {err, busy, mem_valid, pm_rd, r0_we, flag_we}, 0);

        // R1 register numbering and byte order
        wr_reg(3'd2, 8'h34);
        wr_reg(3'd3, 8'h12);
        rd_idx = 3'd2;
        #1 check("R1 readback r26", rd_data, 8'h34);
        issue(3'd0, 2'd1, 6'd0);
        #1 check("R1 X pair forms address", mem_addr, 16'h1234);
        @(negedge clk);
        req_valid = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [1:0]  sel;
            logic [5:0]  imm;
            logic [15:0] init, eaddr, eptr;
            logic        eerr, emem, eflg;
            {op, sel, imm, init, eaddr, eptr, eerr} = VEC[i];
            load_pair(sel, init);
            issue(op, sel, imm);
            req_store = i[0];
            emem = !eerr && (op <= 3'd3);
            eflg = !eerr && (op == 3'd5 || op == 3'd6);
            #2;
            check("R9 err", err, eerr);
            check("R2 mem_valid", mem_valid, emem);
            check("R9 pm_rd suppressed", pm_rd, 1'b0);
            check("R8 flag_we", flag_we, eflg);
            if (emem) begin
                check("R2 R3 R4 R5 address", mem_addr, eaddr);
                check("R2 mem_we", mem_we, i[0]);
            end
            if (eflg) begin
                if (op == 3'd5) begin
                    s = {1'b0, init} + {11'd0, imm};
                    ef = {~init[15] & s[15], s[15], s[15:0] == 16'd0, s[16]};
                end else begin
                    s = {1'b0, init} - {11'd0, imm};
                    ef = {init[15] & ~s[15], s[15], s[15:0] == 16'd0, s[16]};
                end
                check("R7 flags", flags, ef);
            end
            @(negedge clk);
            req_valid = 1'b0;
            req_store = 1'b0;
            read_pair(sel, p);
            check("R3 R4 R7 R9 pointer after", p, eptr);
        end

        // R6 program read, high byte, with a request while busy
        load_pair(2'd3, 16'h0101);
        read_pair(2'd1, p);
        issue(3'd4, 2'd3, 6'd0);
        #1;
        check("R6 pm_rd", pm_rd, 1'b1);
        check("R6 word address", pm_waddr, 15'h0080);
        check("R8 no flags on program read", flag_we, 1'b0);
        @(negedge clk);
        issue(3'd1, 2'd1, 6'd0);
        pm_rdata = 16'hABCD;
        #1;
        check("R6 busy", busy, 1'b1);
        check("R6 r0_we", r0_we, 1'b1);
        check("R6 high byte", r0_data, 8'hAB);
        check("R9 busy request rejected", {err, mem_valid}, 2'b10);
        @(negedge clk);
        req_valid = 1'b0;
        begin
            logic [15:0] q;
            read_pair(2'd1, q);
            check("R9 X untouched by busy request", q, p);
            read_pair(2'd3, q);
            check("R6 Z unchanged", q, 16'h0101);
        end
        check("R6 back to ready", {busy, r0_we}, 2'b00);

        // R6 low byte
        load_pair(2'd3, 16'h0100);
        issue(3'd4, 2'd3, 6'd0);
        @(negedge clk);
        req_valid = 1'b0;
        #1 check("R6 low byte", r0_data, 8'hCD);
        @(negedge clk);

        // R10 collision on the same register
        load_pair(2'd1, 16'h00FF);
        issue(3'd1, 2'd1, 6'd0);
        reg_we = 1'b1; reg_idx = 3'd2; reg_wdata = 8'h55;
        @(negedge clk);
        req_valid = 1'b0; reg_we = 1'b0;
        read_pair(2'd1, p);
        check("R10 update wins", p, 16'h0100);

        // R10 other register still written
        load_pair(2'd2, 16'h0010);
        issue(3'd2, 2'd2, 6'd0);
        reg_we = 1'b1; reg_idx = 3'd0; reg_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0; reg_we = 1'b0;
        rd_idx = 3'd0;
        #1 check("R10 other write lands", rd_data, 8'h77);
        read_pair(2'd2, p);
        check("R4 Y after predec", p, 16'h000F);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule